// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is the storage stage that follows one sum-of-products site in a programmable logic array. It forms the cell's logic input as the XOR of the site's OR sum and a dedicated product-term leg, and stores that value in a flop. Configuration selects D or T behaviour, a clock source with optional inversion, and a clock enable. The cell drives either the stored value or the raw XOR result toward the interconnect, and passes a product-term output enable toward the pad.

The clock enable never gates the clock. It is a recirculating multiplexer in front of the flop. The enable can be taken from the set product term or from the reset product term, and a term used this way loses its asynchronous role. Asynchronous clear and preset come from product terms and from a global set/reset line. The global line loads a configurable initial value, and any clear source beats any preset source.

Top module: `macrocell_reg`

## Requirements
- R1: With `cfgToggle`=0 and the enable active, each active clock edge stores `sumIn ^ xorLeg`. With `cfgBypass`=0, `cellOut` shows the stored value.
- R2: With `cfgToggle`=1 and the enable active, each active clock edge stores the old value XOR (`sumIn ^ xorLeg`).
- R3: `cfgCeSrc` picks the enable source. 0 and 3 mean always enabled. 1 means `ptSet` is an active-high enable. 2 means `ptRst` is an active-high enable. While the enable is low, the stored value holds across clock edges. A term that serves as the enable has no asynchronous effect.
- R4: `cfgClkSel` values 0..2 select `gclk[value]`, and value 3 selects `ptClk`. Edges on clocks that are not selected do not change the stored value.
- R5: With `cfgClkInv`=1, the flop captures on the falling edge of the selected clock and ignores its rising edge.
- R6: `ptRst` (when not the enable) clears the stored value at once, with no clock. `ptSet` (when not the enable) presets it at once. When any clear source and any preset source are active together, the stored value is 0.
- R7: While `gsr` is high, the stored value equals `cfgInitVal` at once. After `gsr` falls, the value is kept until the next enabled edge.
- R8: With `cfgBypass`=1, `cellOut` equals `sumIn ^ xorLeg` combinationally, and the flop keeps updating underneath.
- R9: `oeOut` follows `ptOe` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | GCLK_COUNT (3) | Global clocks |
| ptClk | input | 1 | Product-term clock |
| gsr | input | 1 | Global set/reset, active high, loads `cfgInitVal` |
| sumIn | input | 1 | OR sum of the site's product terms |
| xorLeg | input | 1 | Dedicated product term on the second XOR input |
| ptSet | input | 1 | Set product term (async preset or enable) |
| ptRst | input | 1 | Reset product term (async clear or enable) |
| ptOe | input | 1 | Output-enable product term |
| cfgClkSel | input | 2 | Clock source select (3 = product-term clock) |
| cfgClkInv | input | 1 | Invert the selected clock |
| cfgToggle | input | 1 | 1 = T type, 0 = D type |
| cfgCeSrc | input | 2 | Enable source (0/3 none, 1 set term, 2 reset term) |
| cfgBypass | input | 1 | 1 = drive the combinational XOR result out |
| cfgInitVal | input | 1 | Value loaded by `gsr` |
| cellOut | output | 1 | Cell output toward the interconnect |
| oeOut | output | 1 | Output enable toward the pad |

## Verification
D mode is driven with all four combinations of the sum and the XOR leg, so a wrong or missing XOR stage gives a wrong stored bit. T mode is driven with sequences that mix toggle and no-toggle steps, which separates toggling from loading. The enable is tried from both product terms, with the term asserted between edges, which separates a data mux from a term that still acts asynchronously. Edges are applied on every clock source while only one is selected, and on both polarities, to show that the cell captures only on the chosen edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    CE_ALWAYS   = 2'd0,
    CE_FROM_SET = 2'd1,
    CE_FROM_RST = 2'd2,
    CE_ALWAYS_B = 2'd3
  } ceSrc_e;

  typedef struct packed {
    logic clrAct;
    logic preAct;
    logic ceAct;
    logic toggle;
    logic bypass;
  } mcStrobes_t;

endpackage

// File: rtl/mcell_clksel.sv
module mcell_clksel #(
  parameter int GCLK_COUNT = 3,
  localparam int SRC_COUNT = GCLK_COUNT + 1,
  localparam int SEL_W = $clog2(SRC_COUNT)
) (
  input  logic [GCLK_COUNT-1:0] gclk,
  input  logic                  ptClk,
  input  logic [SEL_W-1:0]      cfgClkSel,
  input  logic                  cfgClkInv,
  output logic                  cellClk
);

  logic [SRC_COUNT-1:0] srcVec;
  logic [SRC_COUNT-1:0] hit;

  assign srcVec = {ptClk, gclk};

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
    if (i < GCLK_COUNT) begin : g_glob
      assign hit[i] = (cfgClkSel == SEL_W'(i));
    end else begin : g_pterm
      assign hit[i] = (cfgClkSel >= SEL_W'(GCLK_COUNT));
    end
  end

  assign cellClk = (|(hit & srcVec)) ^ cfgClkInv;

  // R4: exactly one source is picked for any select value
  always_comb begin
    if (!$isunknown(cfgClkSel)) begin
      p_one_source_r4: assert ($onehot(hit));
    end
  end

endmodule

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
(
  input  logic       gsr,
  input  logic       ptSet,
  input  logic       ptRst,
  input  logic [1:0] cfgCeSrc,
  input  logic       cfgToggle,
  input  logic       cfgBypass,
  input  logic       cfgInitVal,
  output mcStrobes_t strobes
);

  ceSrc_e ceSrc;
  logic   setIsCe;
  logic   rstIsCe;

  assign ceSrc   = ceSrc_e'(cfgCeSrc);
  assign setIsCe = (ceSrc == CE_FROM_SET);
  assign rstIsCe = (ceSrc == CE_FROM_RST);

  always_comb begin
    strobes.clrAct = (gsr & ~cfgInitVal) | (ptRst & ~rstIsCe);
    strobes.preAct = (gsr & cfgInitVal) | (ptSet & ~setIsCe);
    if (setIsCe)      strobes.ceAct = ptSet;
    else if (rstIsCe) strobes.ceAct = ptRst;
    else              strobes.ceAct = 1'b1;
    strobes.toggle = cfgToggle;
    strobes.bypass = cfgBypass;
  end

  // R3: a set term that serves as the enable never presets the flop
  always_comb begin
    if (!$isunknown({cfgCeSrc, gsr, strobes.preAct}) && setIsCe && !gsr) begin
      p_set_term_not_async_r3: assert (!strobes.preAct);
    end
  end

endmodule

// File: rtl/mcell_dp.sv
module mcell_dp
  import mcell_pkg::*;
(
  input  logic       cellClk,
  input  logic       gsr,
  input  logic       sumIn,
  input  logic       xorLeg,
  input  mcStrobes_t strobes,
  output logic       cellOut
);

  logic dIn;
  logic nextQ;
  logic q;
  logic clrAct;
  logic preAct;
  logic asyncAny;
  logic asyncSeen;

  assign dIn      = sumIn ^ xorLeg;
  assign clrAct   = strobes.clrAct;
  assign preAct   = strobes.preAct;
  assign asyncAny = clrAct | preAct;
  assign nextQ    = strobes.toggle ? (q ^ dIn) : dIn;

  // Clear beats preset; the enable only selects between new data and q.
  always_ff @(posedge cellClk or posedge clrAct or posedge preAct) begin
    if (clrAct)             q <= 1'b0;
    else if (preAct)        q <= 1'b1;
    else if (strobes.ceAct) q <= nextQ;
  end

  assign cellOut = strobes.bypass ? dIn : q;

  // Marks an edge whose preceding interval saw an asynchronous load.
  always_ff @(posedge cellClk or posedge asyncAny) begin
    if (asyncAny) asyncSeen <= 1'b1;
    else          asyncSeen <= 1'b0;
  end

  p_d_capture_r1: assert property (@(posedge cellClk) disable iff (asyncAny)
    ($past(strobes.ceAct && !strobes.toggle) && !asyncSeen) |-> (q == $past(dIn)));

  p_toggle_r2: assert property (@(posedge cellClk) disable iff (asyncAny)
    ($past(strobes.ceAct && strobes.toggle) && !asyncSeen) |-> (q == ($past(q) ^ $past(dIn))));

  p_hold_disabled_r3: assert property (@(posedge cellClk) disable iff (asyncAny)
    ($past(!strobes.ceAct) && !asyncSeen) |-> $stable(q));

  p_clear_wins_r6: assert property (@(posedge cellClk) disable iff (gsr)
    (clrAct && preAct) |-> !q);

endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg
  import mcell_pkg::*;
#(
  parameter int GCLK_COUNT = 3,
  localparam int SEL_W = $clog2(GCLK_COUNT + 1)
) (
  input  logic [GCLK_COUNT-1:0] gclk,
  input  logic                  ptClk,
  input  logic                  gsr,
  input  logic                  sumIn,
  input  logic                  xorLeg,
  input  logic                  ptSet,
  input  logic                  ptRst,
  input  logic                  ptOe,
  input  logic [SEL_W-1:0]      cfgClkSel,
  input  logic                  cfgClkInv,
  input  logic                  cfgToggle,
  input  logic [1:0]            cfgCeSrc,
  input  logic                  cfgBypass,
  input  logic                  cfgInitVal,
  output logic                  cellOut,
  output logic                  oeOut
);

  logic       cellClk;
  mcStrobes_t strobes;

  mcell_clksel #(.GCLK_COUNT(GCLK_COUNT)) u_clksel (
    .gclk      (gclk),
    .ptClk     (ptClk),
    .cfgClkSel (cfgClkSel),
    .cfgClkInv (cfgClkInv),
    .cellClk   (cellClk)
  );

  mcell_ctrl u_ctrl (
    .gsr        (gsr),
    .ptSet      (ptSet),
    .ptRst      (ptRst),
    .cfgCeSrc   (cfgCeSrc),
    .cfgToggle  (cfgToggle),
    .cfgBypass  (cfgBypass),
    .cfgInitVal (cfgInitVal),
    .strobes    (strobes)
  );

  mcell_dp u_dp (
    .cellClk (cellClk),
    .gsr     (gsr),
    .sumIn   (sumIn),
    .xorLeg  (xorLeg),
    .strobes (strobes),
    .cellOut (cellOut)
  );

  assign oeOut = ptOe;

endmodule

// File: tb/tb_macrocell_reg.sv
`timescale 1ns/100ps
module tb_macrocell_reg;

  logic [2:0] gclk = 3'b000;
  logic ptClk = 1'b0;
  logic gsr = 1'b0;
  logic sumIn = 1'b0, xorLeg = 1'b0;
  logic ptSet = 1'b0, ptRst = 1'b0, ptOe = 1'b0;
  logic [1:0] cfgClkSel = 2'd0;
  logic cfgClkInv = 1'b0, cfgToggle = 1'b0;
  logic [1:0] cfgCeSrc = 2'd0;
  logic cfgBypass = 1'b0, cfgInitVal = 1'b0;
  logic cellOut, oeOut;

  int testsRun = 0;
  int testsFailed = 0;
  logic expQ;

  macrocell_reg dut (
    .gclk(gclk), .ptClk(ptClk), .gsr(gsr), .sumIn(sumIn), .xorLeg(xorLeg),
    .ptSet(ptSet), .ptRst(ptRst), .ptOe(ptOe), .cfgClkSel(cfgClkSel),
    .cfgClkInv(cfgClkInv), .cfgToggle(cfgToggle), .cfgCeSrc(cfgCeSrc),
    .cfgBypass(cfgBypass), .cfgInitVal(cfgInitVal), .cellOut(cellOut), .oeOut(oeOut)
  );

  always #2 gclk[0] = ~gclk[0];

  task automatic check(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick0();
    @(negedge gclk[0]);
    #1;
  endtask

  task automatic pulse(input int which);
    #0.2;
    if (which == 3) ptClk = 1'b1; else gclk[which] = 1'b1;
    #0.2;
    if (which == 3) ptClk = 1'b0; else gclk[which] = 1'b0;
    #0.1;
  endtask

  task automatic t_reset();
    tick0();
    check("R7 gsr with init 0", cellOut, 1'b0);
    cfgInitVal = 1'b1; #0.2;
    check("R7 gsr loads init 1 at once", cellOut, 1'b1);
    cfgInitVal = 1'b0; #0.2;
    check("R7 gsr loads init 0 at once", cellOut, 1'b0);
    cfgInitVal = 1'b1; #0.2;
    tick0();
    gsr = 1'b0; #0.2;
    check("R7 value kept after gsr falls", cellOut, 1'b1);
    cfgInitVal = 1'b0;
  endtask

  task automatic t_dmode();
    logic [1:0] pats [5] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b10};
    tick0();
    for (int i = 0; i < 5; i++) begin
      sumIn = pats[i][1]; xorLeg = pats[i][0];
      tick0();
      check("R1 d capture", cellOut, pats[i][1] ^ pats[i][0]);
    end
  endtask

  task automatic t_tmode();
    logic [1:0] pats [4] = '{2'b10, 2'b01, 2'b11, 2'b10};
    sumIn = 1'b0; xorLeg = 1'b0;
    tick0();
    expQ = 1'b0;
    cfgToggle = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sumIn = pats[i][1]; xorLeg = pats[i][0];
      expQ = expQ ^ (pats[i][1] ^ pats[i][0]);
      tick0();
      check("R2 toggle step", cellOut, expQ);
    end
    cfgToggle = 1'b0;
  endtask

  task automatic t_enable();
    sumIn = 1'b0; xorLeg = 1'b0;
    tick0();
    cfgCeSrc = 2'd1; ptSet = 1'b0; sumIn = 1'b1;
    tick0(); tick0();
    check("R3 hold with set-term enable low", cellOut, 1'b0);
    ptSet = 1'b1; #0.2;
    check("R3 set term as enable has no async effect", cellOut, 1'b0);
    tick0();
    check("R3 capture with set-term enable high", cellOut, 1'b1);
    ptSet = 1'b0;
    cfgCeSrc = 2'd2; ptRst = 1'b0; sumIn = 1'b0;
    tick0();
    check("R3 hold with reset-term enable low", cellOut, 1'b1);
    ptRst = 1'b1; #0.2;
    check("R3 reset term as enable has no async effect", cellOut, 1'b1);
    tick0();
    check("R3 capture with reset-term enable high", cellOut, 1'b0);
    ptRst = 1'b0;
    cfgCeSrc = 2'd3; sumIn = 1'b1;
    tick0();
    check("R3 code 3 always enabled", cellOut, 1'b1);
    cfgCeSrc = 2'd0;
  endtask

  task automatic t_clksel();
    cfgClkSel = 2'd1; sumIn = 1'b0;
    tick0(); tick0();
    check("R4 unselected gclk0 ignored", cellOut, 1'b1);
    pulse(1);
    check("R4 gclk1 captures", cellOut, 1'b0);
    cfgClkSel = 2'd2; sumIn = 1'b1;
    pulse(1);
    check("R4 unselected gclk1 ignored", cellOut, 1'b0);
    pulse(2);
    check("R4 gclk2 captures", cellOut, 1'b1);
    cfgClkSel = 2'd3; sumIn = 1'b0;
    pulse(2);
    check("R4 unselected gclk2 ignored", cellOut, 1'b1);
    pulse(3);
    check("R4 product-term clock captures", cellOut, 1'b0);
    cfgClkSel = 2'd0;
    tick0();
  endtask

  task automatic t_inv();
    sumIn = 1'b0;
    tick0();
    cfgCeSrc = 2'd1; ptSet = 1'b0;
    cfgClkInv = 1'b1;
    #0.2;
    cfgCeSrc = 2'd0;
    @(negedge gclk[0]); #0.5;
    sumIn = 1'b1;
    @(posedge gclk[0]); #0.2;
    check("R5 rising edge ignored when inverted", cellOut, 1'b0);
    @(negedge gclk[0]); #0.2;
    check("R5 falling edge captures when inverted", cellOut, 1'b1);
    cfgCeSrc = 2'd1;
    cfgClkInv = 1'b0;
    #0.2;
    cfgCeSrc = 2'd0;
    tick0();
  endtask

  task automatic t_async();
    sumIn = 1'b1; xorLeg = 1'b0;
    tick0();
    ptRst = 1'b1; #0.2;
    check("R6 reset term clears without clock", cellOut, 1'b0);
    tick0();
    check("R6 clear holds over clock", cellOut, 1'b0);
    ptRst = 1'b0; sumIn = 1'b0;
    ptSet = 1'b1; #0.2;
    check("R6 set term presets without clock", cellOut, 1'b1);
    ptRst = 1'b1; #0.2;
    check("R6 clear wins over preset", cellOut, 1'b0);
    ptSet = 1'b0; ptRst = 1'b0;
    tick0();
    cfgInitVal = 1'b1; sumIn = 1'b1;
    tick0();
    ptRst = 1'b1; gsr = 1'b1; #0.2;
    check("R6 reset term beats gsr preset", cellOut, 1'b0);
    ptRst = 1'b0;
    tick0();
    gsr = 1'b0; cfgInitVal = 1'b0; sumIn = 1'b0;
    tick0();
  endtask

  task automatic t_bypass();
    check("R8 pre-state", cellOut, 1'b0);
    cfgBypass = 1'b1; sumIn = 1'b1; xorLeg = 1'b0; #0.2;
    check("R8 bypass shows xor at once", cellOut, 1'b1);
    xorLeg = 1'b1; #0.2;
    check("R8 bypass follows xor leg", cellOut, 1'b0);
    xorLeg = 1'b0;
    tick0();
    sumIn = 1'b0;
    cfgBypass = 1'b0; #0.2;
    check("R8 flop updated under bypass", cellOut, 1'b1);
  endtask

  task automatic t_oe();
    ptOe = 1'b1; #0.2;
    check("R9 oe high", oeOut, 1'b1);
    ptOe = 1'b0; #0.2;
    check("R9 oe low", oeOut, 1'b0);
  endtask

  initial begin
    #100000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1 gsr = 1'b1;
    t_reset();
    t_dmode();
    t_tmode();
    t_enable();
    t_clksel();
    t_inv();
    t_async();
    t_bypass();
    t_oe();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule